// File: doc/BRIEF.md
# Multi-Region Image Histogram Engine

The block builds intensity histograms from a raw pixel stream. Each valid pixel carries a 2-bit colour-filter phase and a pixel value. The value is scaled by the gain for its phase, saturated, and reduced to a bin index. It is then counted in every active rectangular region that contains it. Up to four regions share one bin memory, laid out as consecutive blocks. The bins per region shrink as regions are added, so the layout always fits the memory.

Software drives a small register port. It uses this port to set enable, bin count, colour mode, region count, clear-on-read, the gains and the region bounds. It then reads the bins through an auto-incrementing data window. With clear-on-read set, the window zeroes each word as it returns it, except while a frame is being collected. A busy output shows that frame collection is in progress.

Top module: `hist_engine`

Register map (4-bit word address): 0 = enable (bit 0 enable, bit 1 busy, read-only); 1 = control (bits 1:0 bin select, bit 2 colour mode, bits 4:3 region count minus one, bit 5 clear-on-read); 2 = gains (gain for phase p in bits 8p+7:8p); 3 = read pointer (write only); 4 = data window; 8+2k = region k columns; 9+2k = region k lines. Each bound register holds the start in bits 9:0 and the end in bits 25:16.

## Requirements
- R1: Bin select s (control bits 1:0) gives 32<<s bins. The bin index is the gained value shifted right by (10 - (5+s)).
- R2: The gained value is floor(pixel * gain[phase] / 32), with the 8-bit gain read as 3.5 fixed point (0x20 = 1.0). It saturates at 1023. In Bayer mode (control bit 2 = 0) phase p uses gain p.
- R3: The effective bin select is limited to 3 with one region, 2 with two regions and 1 with three or four regions. Any larger request is clamped down.
- R4: Region k counts into memory word k*(bins) + index.
- R5: Bounds are inclusive column/line numbers, counted from the start-of-frame pixel. A pixel is counted once in every active region holding both of its coordinates. Region slots at or above the configured count are ignored.
- R6: In three-layer mode (control bit 2 = 1), pixels of phase 3 are not counted and gain 3 is unused.
- R7: Writing register 3 sets the read pointer. Each read of register 4 returns the addressed word zero-extended to 32 bits, then advances the pointer modulo 256.
- R8: With control bit 5 set and busy low, each data-window read zeroes the word it returns.
- R9: A data-window read while busy is high returns the word and leaves it unchanged.
- R10: Bin counters are CNT_W bits wide (default 20) and stop at 2^CNT_W - 1.
- R11: Pixels arriving while enable is low change no bin.
- R12: Busy rises on the cycle after the first enabled valid pixel. It stays high through the cycle after the end-of-frame pixel, then falls unless another pixel arrives.
- R13: After reset all registers read zero, busy is low and every bin is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel valid |
| pix_sof_i | input | 1 | First pixel of frame |
| pix_eol_i | input | 1 | Last pixel of line |
| pix_eof_i | input | 1 | Last pixel of frame |
| pix_phase_i | input | 2 | Colour-filter phase of the pixel |
| pix_data_i | input | PIX_W | Pixel value |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (advances the data window) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| busy_o | output | 1 | Frame collection in progress |

## Verification
A pixel driven before a clock edge is registered at that edge and lands in its bin at the next edge. The bench therefore waits at least three idle cycles after a frame before any readout. Register writes take effect at the edge that samples them. Read data is combinational on the current pointer and is sampled just after the strobe is driven, before the edge that advances the pointer and applies any clear. Busy is sampled at the negative edge after the first pixel, after the end-of-frame pixel, and one cycle after that. This matches its one-edge rise and the one-cycle hold after end of frame.

// File: rtl/hist_pkg.sv
`timescale 1ns/1ps
package hist_pkg;
  localparam int NUM_REG     = 4;
  localparam int MIN_BIN_LOG = 5;
  localparam int MAX_BIN_LOG = MIN_BIN_LOG + 3;

  localparam logic [3:0] ADR_EN   = 4'h0;
  localparam logic [3:0] ADR_CTRL = 4'h1;
  localparam logic [3:0] ADR_GAIN = 4'h2;
  localparam logic [3:0] ADR_PTR  = 4'h3;
  localparam logic [3:0] ADR_DATA = 4'h4;

  typedef struct packed {
    logic       clr_rd;
    logic [1:0] nreg_m1;
    logic       three_layer;
    logic [1:0] bin_sel;
  } ctrl_t;
endpackage

// File: rtl/hist_regs.sv
`timescale 1ns/1ps
module hist_regs
  import hist_pkg::*;
#(
  parameter int GAIN_W  = 8,
  parameter int COORD_W = 10,
  parameter int CNT_W   = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [3:0]         addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [CNT_W-1:0]   data_word_i,
  input  logic               busy_i,
  output logic [31:0]        rdata_o,
  output logic               en_o,
  output ctrl_t              ctrl_o,
  output logic [GAIN_W-1:0]  gain_o [NUM_REG],
  output logic [COORD_W-1:0] hs_o [NUM_REG],
  output logic [COORD_W-1:0] he_o [NUM_REG],
  output logic [COORD_W-1:0] vs_o [NUM_REG],
  output logic [COORD_W-1:0] ve_o [NUM_REG]
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[15:COORD_W], wdata_i[31:16+COORD_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      ctrl_o <= '0;
      for (int k = 0; k < NUM_REG; k++) begin
        gain_o[k] <= '0;
        hs_o[k] <= '0; he_o[k] <= '0; vs_o[k] <= '0; ve_o[k] <= '0;
      end
    end else if (we_i) begin
      if (addr_i == ADR_EN)   en_o   <= wdata_i[0];
      if (addr_i == ADR_CTRL) ctrl_o <= ctrl_t'(wdata_i[5:0]);
      if (addr_i == ADR_GAIN)
        for (int k = 0; k < NUM_REG; k++) gain_o[k] <= wdata_i[k*8 +: GAIN_W];
      if (addr_i[3]) begin
        if (!addr_i[0]) begin
          hs_o[addr_i[2:1]] <= wdata_i[COORD_W-1:0];
          he_o[addr_i[2:1]] <= wdata_i[16 +: COORD_W];
        end else begin
          vs_o[addr_i[2:1]] <= wdata_i[COORD_W-1:0];
          ve_o[addr_i[2:1]] <= wdata_i[16 +: COORD_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[3]) begin
      if (!addr_i[0]) begin
        rdata_o[COORD_W-1:0]   = hs_o[addr_i[2:1]];
        rdata_o[16 +: COORD_W] = he_o[addr_i[2:1]];
      end else begin
        rdata_o[COORD_W-1:0]   = vs_o[addr_i[2:1]];
        rdata_o[16 +: COORD_W] = ve_o[addr_i[2:1]];
      end
    end else begin
      case (addr_i)
        ADR_EN:   rdata_o[1:0] = {busy_i, en_o};
        ADR_CTRL: rdata_o[5:0] = ctrl_o;
        ADR_GAIN: for (int k = 0; k < NUM_REG; k++) rdata_o[k*8 +: GAIN_W] = gain_o[k];
        ADR_DATA: rdata_o[CNT_W-1:0] = data_word_i;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/hist_front.sv
`timescale 1ns/1ps
module hist_front
  import hist_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5,
  parameter int COORD_W   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               three_layer_i,
  input  logic [GAIN_W-1:0]  gain_i [NUM_REG],
  input  logic               pix_valid_i,
  input  logic               pix_sof_i,
  input  logic               pix_eol_i,
  input  logic               pix_eof_i,
  input  logic [1:0]         pix_phase_i,
  input  logic [PIX_W-1:0]   pix_data_i,
  output logic               s1_valid_o,
  output logic [PIX_W-1:0]   s1_val_o,
  output logic [COORD_W-1:0] s1_x_o,
  output logic [COORD_W-1:0] s1_y_o,
  output logic               busy_o
);
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam logic [PROD_W-1:0] SAT_LIM = PROD_W'((1 << PIX_W) - 1);

  logic [COORD_W-1:0] x_q, y_q, cur_x, cur_y;
  logic [PROD_W-1:0]  prod, scaled;
  logic [PIX_W-1:0]   gained;
  logic               take, drop, last_q;

  always_comb begin
    cur_x  = pix_sof_i ? '0 : x_q;
    cur_y  = pix_sof_i ? '0 : y_q;
    prod   = PROD_W'(pix_data_i) * PROD_W'(gain_i[pix_phase_i]);
    scaled = prod >> GAIN_FRAC;
    gained = (scaled > SAT_LIM) ? '1 : scaled[PIX_W-1:0];
    drop   = three_layer_i && (pix_phase_i == 2'd3);
    take   = pix_valid_i && en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0; y_q <= '0;
      s1_valid_o <= 1'b0; s1_val_o <= '0; s1_x_o <= '0; s1_y_o <= '0;
      busy_o <= 1'b0; last_q <= 1'b0;
    end else begin
      if (pix_valid_i) begin
        x_q <= pix_eol_i ? '0 : cur_x + 1'b1;
        y_q <= pix_eol_i ? cur_y + 1'b1 : cur_y;
      end
      s1_valid_o <= take && !drop;
      s1_val_o   <= gained;
      s1_x_o     <= cur_x;
      s1_y_o     <= cur_y;
      last_q     <= take && pix_eof_i;
      if (take)        busy_o <= 1'b1;
      else if (last_q) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hist_match.sv
`timescale 1ns/1ps
module hist_match
  import hist_pkg::*;
#(
  parameter int PIX_W   = 10,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 8
) (
  input  logic               s1_valid_i,
  input  logic [PIX_W-1:0]   val_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [1:0]         nreg_m1_i,
  input  logic [1:0]         bin_sel_i,
  input  logic [COORD_W-1:0] hs_i [NUM_REG],
  input  logic [COORD_W-1:0] he_i [NUM_REG],
  input  logic [COORD_W-1:0] vs_i [NUM_REG],
  input  logic [COORD_W-1:0] ve_i [NUM_REG],
  output logic [NUM_REG-1:0] hit_o,
  output logic [ADDR_W-1:0]  addr_o [NUM_REG],
  output logic [1:0]         eff_sel_o
);
  logic [1:0]       max_sel;
  logic [PIX_W-1:0] idx;

  always_comb begin
    case (nreg_m1_i)
      2'd0:    max_sel = 2'd3;
      2'd1:    max_sel = 2'd2;
      default: max_sel = 2'd1;
    endcase
    eff_sel_o = (bin_sel_i > max_sel) ? max_sel : bin_sel_i;
    idx = val_i >> (PIX_W - MIN_BIN_LOG - int'(eff_sel_o));
  end

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    logic in_h, in_v;
    logic [ADDR_W+2:0] base;
    assign in_h     = (x_i >= hs_i[k]) && (x_i <= he_i[k]);
    assign in_v     = (y_i >= vs_i[k]) && (y_i <= ve_i[k]);
    assign hit_o[k] = s1_valid_i && (int'(nreg_m1_i) >= k) && in_h && in_v;
    assign base     = (ADDR_W+3)'(k) << (MIN_BIN_LOG + int'(eff_sel_o));
    assign addr_o[k] = ADDR_W'(base) + ADDR_W'(idx);
  end
endmodule

// File: rtl/hist_bins.sv
`timescale 1ns/1ps
module hist_bins
  import hist_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REG-1:0] hit_i,
  input  logic [ADDR_W-1:0]  addr_i [NUM_REG],
  input  logic               ptr_we_i,
  input  logic [ADDR_W-1:0]  ptr_wdata_i,
  input  logic               rd_i,
  input  logic               clr_en_i,
  input  logic               busy_i,
  output logic [CNT_W-1:0]   rd_word_o,
  output logic [ADDR_W-1:0]  rd_ptr_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] mem [DEPTH];

  assign rd_word_o = mem[rd_ptr_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (ptr_we_i)  rd_ptr_o <= ptr_wdata_i;
      else if (rd_i) rd_ptr_o <= rd_ptr_o + 1'b1;
      if (rd_i && clr_en_i && !busy_i) mem[rd_ptr_o] <= '0;
      // regions own disjoint blocks, so per-pixel updates never collide
      for (int k = 0; k < NUM_REG; k++)
        if (hit_i[k] && (mem[addr_i[k]] != CNT_MAX))
          mem[addr_i[k]] <= mem[addr_i[k]] + 1'b1;
    end
  end
endmodule

// File: rtl/hist_engine.sv
`timescale 1ns/1ps
module hist_engine
  import hist_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5,
  parameter int COORD_W   = 10,
  parameter int CNT_W     = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic             pix_sof_i,
  input  logic             pix_eol_i,
  input  logic             pix_eof_i,
  input  logic [1:0]       pix_phase_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             busy_o
);
  localparam int ADDR_W = MAX_BIN_LOG;

  logic               en_q;
  ctrl_t              ctrl;
  logic [GAIN_W-1:0]  gain [NUM_REG];
  logic [COORD_W-1:0] hs [NUM_REG], he [NUM_REG], vs [NUM_REG], ve [NUM_REG];
  logic               s1_valid;
  logic [PIX_W-1:0]   s1_val;
  logic [COORD_W-1:0] s1_x, s1_y;
  logic [NUM_REG-1:0] hit;
  logic [ADDR_W-1:0]  bin_addr [NUM_REG];
  logic [1:0]         eff_sel;
  logic [CNT_W-1:0]   rd_word;
  logic [ADDR_W-1:0]  rd_ptr;
  logic               ptr_we, data_rd;

  assign ptr_we  = reg_we_i && (reg_addr_i == ADR_PTR);
  assign data_rd = reg_re_i && (reg_addr_i == ADR_DATA);

  hist_regs #(.GAIN_W(GAIN_W), .COORD_W(COORD_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .data_word_i(rd_word), .busy_i(busy_o), .rdata_o(reg_rdata_o), .en_o(en_q),
    .ctrl_o(ctrl), .gain_o(gain), .hs_o(hs), .he_o(he), .vs_o(vs), .ve_o(ve)
  );

  hist_front #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .COORD_W(COORD_W)) u_front (
    .clk_i, .rst_ni, .en_i(en_q), .three_layer_i(ctrl.three_layer), .gain_i(gain),
    .pix_valid_i, .pix_sof_i, .pix_eol_i, .pix_eof_i, .pix_phase_i, .pix_data_i,
    .s1_valid_o(s1_valid), .s1_val_o(s1_val), .s1_x_o(s1_x), .s1_y_o(s1_y), .busy_o
  );

  hist_match #(.PIX_W(PIX_W), .COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_match (
    .s1_valid_i(s1_valid), .val_i(s1_val), .x_i(s1_x), .y_i(s1_y),
    .nreg_m1_i(ctrl.nreg_m1), .bin_sel_i(ctrl.bin_sel),
    .hs_i(hs), .he_i(he), .vs_i(vs), .ve_i(ve),
    .hit_o(hit), .addr_o(bin_addr), .eff_sel_o(eff_sel)
  );

  hist_bins #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bins (
    .clk_i, .rst_ni, .hit_i(hit), .addr_i(bin_addr),
    .ptr_we_i(ptr_we), .ptr_wdata_i(reg_wdata_i[ADDR_W-1:0]),
    .rd_i(data_rd), .clr_en_i(ctrl.clr_rd), .busy_i(busy_o),
    .rd_word_o(rd_word), .rd_ptr_o(rd_ptr)
  );
endmodule

// File: rtl/hist_engine_chk.sv
`timescale 1ns/1ps
module hist_engine_chk
  import hist_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pix_valid_i,
  input logic               pix_eof_i,
  input logic               busy_o,
  input logic               en_q,
  input logic [1:0]         nreg_m1,
  input logic [1:0]         eff_sel,
  input logic [NUM_REG-1:0] hit,
  input logic               data_rd,
  input logic               ptr_we,
  input logic [ADDR_W-1:0]  rd_ptr
);
  AST_BUSY_RISE_ON_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(pix_valid_i && en_q)); // R12
  AST_BUSY_HOLD_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_eof_i && en_q) |=> busy_o); // R12
  AST_BUSY_DROP_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_eof_i && en_q) ##1 !pix_valid_i |=> !busy_o); // R12
  AST_NO_COUNT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (hit == '0)); // R11
  AST_ACTIVE_REGIONS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit) <= int'(nreg_m1) + 1); // R5
  AST_BIN_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(nreg_m1) + 1) << (MIN_BIN_LOG + int'(eff_sel))) <= (1 << ADDR_W)); // R3
  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !ptr_we) |=> rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1)); // R7
endmodule

bind hist_engine hist_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_valid_i(pix_valid_i), .pix_eof_i(pix_eof_i),
  .busy_o(busy_o), .en_q(en_q), .nreg_m1(ctrl.nreg_m1), .eff_sel(eff_sel), .hit(hit),
  .data_rd(data_rd), .ptr_we(ptr_we), .rd_ptr(rd_ptr)
);

// File: tb/hist_engine_tb_top.sv
`timescale 1ns/1ps
module hist_engine_tb_top;
  localparam int CNT_W = 10;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pv = 0, sof = 0, eol = 0, eof = 0;
  logic [1:0] phase = '0;
  logic [9:0] pdata = '0;
  logic we = 0, re = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic busy;

  always #5 clk = ~clk;

  hist_engine #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pv), .pix_sof_i(sof), .pix_eol_i(eol),
    .pix_eof_i(eof), .pix_phase_i(phase), .pix_data_i(pdata), .reg_we_i(we),
    .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int model [256];
  int b_en = 0, b_sel = 0, b_mode = 0, b_nreg = 1, b_clr = 0;
  int g [4], hs [4], he [4], vs [4], ve [4];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; addr = a[3:0]; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); re = 1; addr = a[3:0]; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic set_cfg(int sel, int mode, int nreg, int clr);
    b_sel = sel; b_mode = mode; b_nreg = nreg; b_clr = clr;
    wr(1, sel | (mode << 2) | ((nreg - 1) << 3) | (clr << 5));
  endtask

  task automatic set_gains(int g0, int g1, int g2, int g3);
    g[0] = g0; g[1] = g1; g[2] = g2; g[3] = g3;
    wr(2, g0 | (g1 << 8) | (g2 << 16) | (g3 << 24));
  endtask

  task automatic set_region(int k, int h0, int h1, int v0, int v1);
    hs[k] = h0; he[k] = h1; vs[k] = v0; ve[k] = v1;
    wr(8 + 2 * k, h0 | (h1 << 16));
    wr(9 + 2 * k, v0 | (v1 << 16));
  endtask

  function automatic int eff_sel();
    int mx = (b_nreg == 1) ? 3 : (b_nreg == 2) ? 2 : 1;
    return (b_sel > mx) ? mx : b_sel;
  endfunction

  task automatic model_pixel(int x, int y, int ph, int v);
    int gv, bl, idx, a;
    if (b_en == 0) return;
    if (b_mode == 1 && ph == 3) return;
    gv = (v * g[ph]) >> 5;
    if (gv > 1023) gv = 1023;
    bl = 5 + eff_sel();
    idx = gv >> (10 - bl);
    for (int k = 0; k < b_nreg; k++)
      if (x >= hs[k] && x <= he[k] && y >= vs[k] && y <= ve[k]) begin
        a = k * (1 << bl) + idx;
        if (model[a] < CMAX) model[a]++;
      end
  endtask

  task automatic stream(int w, int h, int seed, int first, int last);
    for (int n = first; n <= last; n++) begin
      int x = n % w;
      int y = n / w;
      int v = (x * 53 + y * 97 + seed * 31) % 1024;
      int ph = (y % 2) * 2 + (x % 2);
      @(negedge clk);
      pv = 1; sof = (n == 0); eol = (x == w - 1); eof = (n == w * h - 1);
      phase = ph[1:0]; pdata = v[9:0];
      model_pixel(x, y, ph, v);
    end
    @(negedge clk); pv = 0; sof = 0; eol = 0; eof = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all(string req);
    int d;
    wr(3, 0);
    for (int i = 0; i < 256; i++) begin
      rd(4, d);
      chk(req, d, model[i]);
      if (b_clr == 1) model[i] = 0;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int d;
    for (int i = 0; i < 256; i++) model[i] = 0;
    for (int k = 0; k < 4; k++) begin g[k] = 0; hs[k] = 0; he[k] = 0; vs[k] = 0; ve[k] = 0; end
    idle(3); rst_n = 1; idle(2);

    // R13 reset state
    rd(0, d); chk("R13 enable/busy", d, 0);
    rd(1, d); chk("R13 control", d, 0);
    rd(2, d); chk("R13 gains", d, 0);
    chk("R13 busy", busy, 0);
    read_all("R13 bins");

    // R12 busy timing, R1 unity gain full frame
    wr(0, 1); b_en = 1;
    set_region(0, 0, 1023, 0, 1023);
    set_gains(32, 32, 32, 32);
    set_cfg(3, 0, 1, 1);
    chk("R12 idle after enable", busy, 0);
    stream(8, 4, 1, 0, 0);
    chk("R12 rise", busy, 1);
    stream(8, 4, 1, 1, 31);
    chk("R12 hold after eof", busy, 1);
    idle(1);
    chk("R12 fall", busy, 0);
    idle(3);
    read_all("R1 256 bins");

    // R2 per-phase gains with saturation, 32 bins
    set_gains(16, 32, 64, 255);
    set_cfg(0, 0, 1, 1);
    stream(32, 8, 2, 0, 255); idle(3);
    read_all("R2 gains");

    // R7 pointer load and wrap, clear off
    set_cfg(2, 0, 1, 0);
    stream(32, 8, 3, 0, 255); idle(3);
    wr(3, 100);
    rd(4, d); chk("R7 ptr load", d, model[100]);
    rd(4, d); chk("R7 ptr advance", d, model[101]);
    wr(3, 255);
    rd(4, d); chk("R7 last word", d, model[255]);
    rd(4, d); chk("R7 wrap", d, model[0]);
    read_all("R7 no clear");
    set_cfg(2, 0, 1, 1);
    read_all("R8 clear read");
    read_all("R8 all zero after clear");

    // R3 clamp with two regions
    set_region(0, 0, 15, 0, 3);
    set_region(1, 4, 31, 2, 7);
    set_cfg(3, 0, 2, 1);
    stream(32, 8, 4, 0, 255); idle(3);
    read_all("R3 clamp");

    // R4 four overlapping regions
    set_region(0, 0, 15, 0, 7);
    set_region(1, 2, 5, 1, 3);
    set_region(2, 5, 5, 0, 7);
    set_region(3, 10, 15, 6, 7);
    set_cfg(1, 0, 4, 1);
    stream(16, 8, 5, 0, 127); idle(3);
    read_all("R4 layout");

    // R5 slot 3 programmed but inactive
    set_cfg(1, 0, 3, 1);
    stream(16, 8, 6, 0, 127); idle(3);
    read_all("R5 inactive slot");

    // R6 three-layer mode
    set_region(0, 0, 1023, 0, 1023);
    set_gains(32, 48, 24, 255);
    set_cfg(3, 1, 1, 1);
    stream(16, 8, 7, 0, 127); idle(3);
    read_all("R6 three-layer");

    // R11 disabled
    set_cfg(3, 0, 1, 1);
    wr(0, 0); b_en = 0;
    stream(16, 8, 8, 0, 127); idle(3);
    chk("R11 busy stays low", busy, 0);
    read_all("R11 no counting");
    wr(0, 1); b_en = 1;

    // R9 read while busy does not clear
    set_gains(0, 0, 0, 0);
    stream(8, 4, 9, 0, 4);
    chk("R12 busy mid-frame", busy, 1);
    idle(2);
    wr(3, 0);
    rd(4, d); chk("R9 read while busy", d, 5);
    stream(8, 4, 9, 5, 31); idle(3);
    read_all("R9 word kept");

    // R10 counter saturation
    stream(40, 30, 10, 0, 1199); idle(3);
    chk("R10 model saturated", model[0], CMAX);
    read_all("R10 saturate");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule